// File: doc/BRIEF.md
# Disk Command Register Capture

This block is the device-side register bank of a parallel disk command port. A host writes one byte per cycle. Each write selects a register by a small index. The bank has an address-low, address-mid and address-high register, plus feature, sector-count, device and command registers.

The address, count and feature registers each keep the two most recent bytes written to them. A host that needs a 48-bit block address writes each of these registers twice: the high-order half first, then the low-order half. A host that uses 28-bit addressing writes each register once. In 28-bit mode the top four address bits come from the device register.

A write to the command register decodes the opcode and captures all fields. It then raises a one-cycle command pulse that carries the assembled address, sector count, feature word, drive select and extended-mode flag. An opcode the block does not know raises a one-cycle error pulse instead.

Top module: `taskfile_capture`

## Requirements
- R1: After reset, cmd_valid and cmd_error are low and every stored byte is zero. A read command issued straight after reset therefore reports address 0, feature 0, drive 0 and a count of 256.
- R2: Each write to the feature (index 0), count (index 1), low (index 2), mid (index 3) or high (index 4) register moves that register's current byte into its older slot. The new byte becomes the current byte.
- R3: In extended mode, cmd_lba[47:0] is built from bit 0 upward as low current, mid current, high current, low older, mid older, high older. For example, writes of 0x56 then 0xef to low, 0x34 then 0xcd to mid, and 0x12 then 0xab to high give 0x123456abcdef.
- R4: In 28-bit mode, cmd_lba is {20'b0, device[3:0], high current, mid current, low current}.
- R5: The device register (index 5) holds a single byte. Its bit 4 is reported on cmd_drive1 and its bit 6 on cmd_lba_mode.
- R6: The command register is index 7, and its opcode decodes as follows:
  - 0x20: read, not extended.
  - 0x30: write, not extended.
  - 0x24: read, extended.
  - 0x34: write, extended.
  - 0xec: identify, not extended.

  cmd_op encodes read as 0, write as 1 and identify as 2.
- R7: In extended mode, cmd_count is {count older, count current}, and 0 stays 0. In 28-bit mode, cmd_count is the current count byte, and a current byte of 0 reports 256.
- R8: In extended mode, cmd_feature is {feature older, feature current}. Otherwise it is {8'h00, feature current}.
- R9: A command write with a known opcode raises cmd_valid in the next cycle only. The captured fields reflect the registers as they were before that write. A register write in the pulse cycle does not change the fields shown during the pulse.
- R10: A command write with an unknown opcode raises cmd_error for one cycle and leaves cmd_valid low.
- R11: A write to index 6 changes no register. A following command reports exactly the values it would have reported without that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_idx | input | 3 | Register index |
| wr_data | input | 8 | Byte to write |
| cmd_valid | output | 1 | One-cycle pulse for an accepted command |
| cmd_error | output | 1 | One-cycle pulse for an unknown opcode |
| cmd_op | output | 2 | 0 read, 1 write, 2 identify |
| cmd_ext | output | 1 | Extended 48-bit form |
| cmd_lba | output | 48 | Assembled block address |
| cmd_count | output | 16 | Sector count |
| cmd_feature | output | 16 | Feature word |
| cmd_drive1 | output | 1 | Second drive selected |
| cmd_lba_mode | output | 1 | Block addressing flag from the device register |

## Verification
The command pulse and a fresh register write can share a cycle. The host is free to write the address-low register in the cycle right after a command write, while cmd_valid is still high. The bench provokes this overlap on purpose, and it also issues two command writes back to back. A scoreboard then checks two things: that the pulse shows the fields from before the overlapping write, and that the next command sees the shifted bytes.

// File: rtl/taskfile_pkg.sv
package taskfile_pkg;

   typedef enum logic [1:0] {
      TF_OP_READ  = 2'd0,
      TF_OP_WRITE = 2'd1,
      TF_OP_IDENT = 2'd2
   } tf_op_e;

   typedef struct packed {
      logic   known;
      tf_op_e op;
      logic   ext;
   } tf_dec_t;

   // slots of the paired-byte array
   localparam int SLOT_FEAT = 0;
   localparam int SLOT_CNT  = 1;
   localparam int SLOT_LOW  = 2;
   localparam int SLOT_MID  = 3;
   localparam int SLOT_HIGH = 4;
   localparam int SLOT_N    = 5;

endpackage

// File: rtl/tf_byte_pair.sv
module tf_byte_pair #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              we,
   input  logic [BYTE_W-1:0] din,
   output logic [BYTE_W-1:0] cur,
   output logic [BYTE_W-1:0] prev
);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur  <= '0;
         prev <= '0;
      end else if (we) begin
         prev <= cur;
         cur  <= din;
      end
   end

   // R2: older slot receives the byte that was current before the write
   p_shift_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (prev == $past(cur)) && (cur == $past(din)));

   // R2: without a write both slots hold
   p_hold_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(cur) && $stable(prev));

endmodule

// File: rtl/tf_opcode_decode.sv
module tf_opcode_decode
   import taskfile_pkg::*;
#(
   parameter int BYTE_W = 8,
   parameter bit EXT_EN = 1'b1
) (
   input  logic [BYTE_W-1:0] opcode,
   output tf_dec_t           dec
);

   localparam logic [BYTE_W-1:0] OPC_RD   = BYTE_W'(8'h20);
   localparam logic [BYTE_W-1:0] OPC_WR   = BYTE_W'(8'h30);
   localparam logic [BYTE_W-1:0] OPC_RDX  = BYTE_W'(8'h24);
   localparam logic [BYTE_W-1:0] OPC_WRX  = BYTE_W'(8'h34);
   localparam logic [BYTE_W-1:0] OPC_IDN  = BYTE_W'(8'hec);

   tf_dec_t base_dec;

   always_comb begin
      base_dec = '{known: 1'b0, op: TF_OP_READ, ext: 1'b0};
      unique case (opcode)
         OPC_RD:  base_dec = '{known: 1'b1, op: TF_OP_READ,  ext: 1'b0};
         OPC_WR:  base_dec = '{known: 1'b1, op: TF_OP_WRITE, ext: 1'b0};
         OPC_RDX: base_dec = '{known: 1'b1, op: TF_OP_READ,  ext: 1'b1};
         OPC_WRX: base_dec = '{known: 1'b1, op: TF_OP_WRITE, ext: 1'b1};
         OPC_IDN: base_dec = '{known: 1'b1, op: TF_OP_IDENT, ext: 1'b0};
         default: base_dec = '{known: 1'b0, op: TF_OP_READ,  ext: 1'b0};
      endcase
   end

   generate
      if (EXT_EN) begin : g_ext
         assign dec = base_dec;
      end else begin : g_noext
         // extended opcodes become unknown when 48-bit support is off
         assign dec = '{known: base_dec.known & ~base_dec.ext,
                        op:    base_dec.op,
                        ext:   1'b0};
      end
   endgenerate

   always_comb begin
      if (dec.ext) assert (dec.known && dec.op != TF_OP_IDENT);
   end

endmodule

// File: rtl/tf_field_assemble.sv
module tf_field_assemble #(
   parameter int BYTE_W = 8,
   parameter int NIB_W  = 4
) (
   input  logic              ext,
   input  logic [BYTE_W-1:0] low_cur,
   input  logic [BYTE_W-1:0] low_prev,
   input  logic [BYTE_W-1:0] mid_cur,
   input  logic [BYTE_W-1:0] mid_prev,
   input  logic [BYTE_W-1:0] high_cur,
   input  logic [BYTE_W-1:0] high_prev,
   input  logic [BYTE_W-1:0] cnt_cur,
   input  logic [BYTE_W-1:0] cnt_prev,
   input  logic [BYTE_W-1:0] feat_cur,
   input  logic [BYTE_W-1:0] feat_prev,
   input  logic [NIB_W-1:0]  dev_nib,
   output logic [6*BYTE_W-1:0] lba,
   output logic [2*BYTE_W-1:0] count,
   output logic [2*BYTE_W-1:0] feature
);

   localparam int LBA_W   = 6 * BYTE_W;
   localparam int SHORT_W = 3 * BYTE_W + NIB_W;
   localparam int WORD_W  = 2 * BYTE_W;
   localparam logic [WORD_W-1:0] FULL_SHORT = WORD_W'(1) << BYTE_W;

   logic [LBA_W-1:0]  lba_long, lba_short;
   logic [WORD_W-1:0] cnt_long, cnt_short;

   assign lba_long  = {high_prev, mid_prev, low_prev, high_cur, mid_cur, low_cur};
   assign lba_short = {{(LBA_W-SHORT_W){1'b0}}, dev_nib, high_cur, mid_cur, low_cur};

   assign cnt_long  = {cnt_prev, cnt_cur};
   assign cnt_short = (cnt_cur == '0) ? FULL_SHORT : {{BYTE_W{1'b0}}, cnt_cur};

   assign lba     = ext ? lba_long : lba_short;
   assign count   = ext ? cnt_long : cnt_short;
   assign feature = ext ? {feat_prev, feat_cur} : {{BYTE_W{1'b0}}, feat_cur};

endmodule

// File: rtl/taskfile_capture.sv
module taskfile_capture
   import taskfile_pkg::*;
#(
   parameter int BYTE_W   = 8,
   parameter int IDX_W    = 3,
   parameter int FEAT_IDX = 0,
   parameter int CNT_IDX  = 1,
   parameter int LOW_IDX  = 2,
   parameter int MID_IDX  = 3,
   parameter int HIGH_IDX = 4,
   parameter int DEV_IDX  = 5,
   parameter int CMD_IDX  = 7,
   parameter bit EXT_EN   = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                wr_en,
   input  logic [IDX_W-1:0]    wr_idx,
   input  logic [BYTE_W-1:0]   wr_data,
   output logic                cmd_valid,
   output logic                cmd_error,
   output logic [1:0]          cmd_op,
   output logic                cmd_ext,
   output logic [6*BYTE_W-1:0] cmd_lba,
   output logic [2*BYTE_W-1:0] cmd_count,
   output logic [2*BYTE_W-1:0] cmd_feature,
   output logic                cmd_drive1,
   output logic                cmd_lba_mode
);

   localparam int LBA_W    = 6 * BYTE_W;
   localparam int WORD_W   = 2 * BYTE_W;
   localparam int NIB_W    = 4;
   localparam int DRV_BIT  = 4;
   localparam int MODE_BIT = 6;
   localparam logic [IDX_W-1:0] IDX_DEV = IDX_W'(DEV_IDX);
   localparam logic [IDX_W-1:0] IDX_CMD = IDX_W'(CMD_IDX);
   localparam int SLOT_IDX [SLOT_N] = '{FEAT_IDX, CNT_IDX, LOW_IDX, MID_IDX, HIGH_IDX};

   generate
      if (BYTE_W < 8) begin : g_bad_w
         $error("taskfile_capture: BYTE_W must be at least 8");
      end
      if ((1 << IDX_W) <= CMD_IDX || (1 << IDX_W) <= DEV_IDX) begin : g_bad_idx
         $error("taskfile_capture: register index does not fit IDX_W");
      end
   endgenerate

   // paired byte registers
   logic [BYTE_W-1:0] cur_b  [SLOT_N];
   logic [BYTE_W-1:0] prev_b [SLOT_N];

   generate
      for (genvar g = 0; g < SLOT_N; g++) begin : g_pair
         logic slot_we;
         assign slot_we = wr_en && (wr_idx == IDX_W'(SLOT_IDX[g]));
         tf_byte_pair #(.BYTE_W(BYTE_W)) u_pair (
            .clk   (clk),
            .rst_n (rst_n),
            .we    (slot_we),
            .din   (wr_data),
            .cur   (cur_b[g]),
            .prev  (prev_b[g])
         );
      end
   endgenerate

   // single-byte device register
   logic [BYTE_W-1:0] dev_q;
   always_ff @(posedge clk) begin
      if (!rst_n)                          dev_q <= '0;
      else if (wr_en && wr_idx == IDX_DEV) dev_q <= wr_data;
   end

   // opcode decode on the write bus
   tf_dec_t dec;
   tf_opcode_decode #(.BYTE_W(BYTE_W), .EXT_EN(EXT_EN)) u_dec (
      .opcode (wr_data),
      .dec    (dec)
   );

   logic [LBA_W-1:0]  asm_lba;
   logic [WORD_W-1:0] asm_cnt, asm_feat;

   tf_field_assemble #(.BYTE_W(BYTE_W), .NIB_W(NIB_W)) u_asm (
      .ext       (dec.ext),
      .low_cur   (cur_b[SLOT_LOW]),
      .low_prev  (prev_b[SLOT_LOW]),
      .mid_cur   (cur_b[SLOT_MID]),
      .mid_prev  (prev_b[SLOT_MID]),
      .high_cur  (cur_b[SLOT_HIGH]),
      .high_prev (prev_b[SLOT_HIGH]),
      .cnt_cur   (cur_b[SLOT_CNT]),
      .cnt_prev  (prev_b[SLOT_CNT]),
      .feat_cur  (cur_b[SLOT_FEAT]),
      .feat_prev (prev_b[SLOT_FEAT]),
      .dev_nib   (dev_q[NIB_W-1:0]),
      .lba       (asm_lba),
      .count     (asm_cnt),
      .feature   (asm_feat)
   );

   logic cmd_hit;
   assign cmd_hit = wr_en && (wr_idx == IDX_CMD);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_valid    <= 1'b0;
         cmd_error    <= 1'b0;
         cmd_op       <= 2'd0;
         cmd_ext      <= 1'b0;
         cmd_lba      <= '0;
         cmd_count    <= '0;
         cmd_feature  <= '0;
         cmd_drive1   <= 1'b0;
         cmd_lba_mode <= 1'b0;
      end else begin
         cmd_valid <= cmd_hit && dec.known;
         cmd_error <= cmd_hit && !dec.known;
         if (cmd_hit && dec.known) begin
            cmd_op       <= dec.op;
            cmd_ext      <= dec.ext;
            cmd_lba      <= asm_lba;
            cmd_count    <= asm_cnt;
            cmd_feature  <= asm_feat;
            cmd_drive1   <= dev_q[DRV_BIT];
            cmd_lba_mode <= dev_q[MODE_BIT];
         end
      end
   end

   // R9: a pulse only follows a command-register write
   p_valid_cause_r9: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |-> $past(wr_en && wr_idx == IDX_CMD));

   // R10: the two pulses never coincide
   p_pulse_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_valid && cmd_error));

   // R10: the error pulse also needs a command write
   p_error_cause_r10: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_error |-> $past(wr_en && wr_idx == IDX_CMD));

   // R4: short addresses leave the upper bits clear
   p_short_upper_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ext) |-> (cmd_lba[LBA_W-1:3*BYTE_W+NIB_W] == '0));

   // R7: a short-form count is never zero
   p_short_count_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && !cmd_ext) |-> (cmd_count != '0));

   // R6: identify is never the extended form
   p_ident_short_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_op == 2'd2) |-> !cmd_ext);

endmodule

// File: tb/tb_taskfile_capture.sv
`timescale 1ns/1ps
module tb_taskfile_capture;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        wr_en = 1'b0;
   logic [2:0]  wr_idx = '0;
   logic [7:0]  wr_data = '0;
   logic        cmd_valid, cmd_error, cmd_ext, cmd_drive1, cmd_lba_mode;
   logic [1:0]  cmd_op;
   logic [47:0] cmd_lba;
   logic [15:0] cmd_count, cmd_feature;

   always #10 clk = ~clk;   // 50 MHz

   taskfile_capture dut (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
      .cmd_valid(cmd_valid), .cmd_error(cmd_error), .cmd_op(cmd_op), .cmd_ext(cmd_ext),
      .cmd_lba(cmd_lba), .cmd_count(cmd_count), .cmd_feature(cmd_feature),
      .cmd_drive1(cmd_drive1), .cmd_lba_mode(cmd_lba_mode)
   );

   typedef struct {
      bit          err;
      logic [1:0]  op;
      bit          ext;
      logic [47:0] lba;
      logic [15:0] cnt;
      logic [15:0] feat;
      bit          drv;
      bit          mode;
      string       tag;
   } exp_t;

   exp_t q[$];
   int   checks = 0;
   int   errors = 0;
   bit   done = 1'b0;

   // bench-side view of the register bytes, built from R2 and R5
   logic [7:0] m_cur [8];
   logic [7:0] m_prv [8];
   logic [7:0] m_dev;

   task automatic fail_line(string req, string what, logic [63:0] act, logic [63:0] expv);
      errors++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, expv);
   endtask

   // R1: model starts from the all-zero reset state
   task automatic model_clear();
      for (int i = 0; i < 8; i++) begin
         m_cur[i] = '0;
         m_prv[i] = '0;
      end
      m_dev = '0;
   endtask

   task automatic wr(input logic [2:0] idx, input logic [7:0] d);
      wr_en = 1'b1; wr_idx = idx; wr_data = d;
      if (idx <= 3'd4) begin
         m_prv[idx] = m_cur[idx];
         m_cur[idx] = d;
      end else if (idx == 3'd5) begin
         m_dev = d;
      end
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic issue(input logic [7:0] opc, input string tag);
      exp_t e;
      e.tag = tag;
      e.err = 1'b0; e.ext = 1'b0; e.op = 2'd0;
      case (opc)
         8'h20: e.op = 2'd0;
         8'h30: e.op = 2'd1;
         8'h24: begin e.op = 2'd0; e.ext = 1'b1; end
         8'h34: begin e.op = 2'd1; e.ext = 1'b1; end
         8'hec: e.op = 2'd2;
         default: e.err = 1'b1;
      endcase
      if (e.ext) begin
         e.lba  = {m_prv[4], m_prv[3], m_prv[2], m_cur[4], m_cur[3], m_cur[2]};
         e.cnt  = {m_prv[1], m_cur[1]};
         e.feat = {m_prv[0], m_cur[0]};
      end else begin
         e.lba  = {20'h0, m_dev[3:0], m_cur[4], m_cur[3], m_cur[2]};
         e.cnt  = (m_cur[1] == 8'h0) ? 16'd256 : {8'h0, m_cur[1]};
         e.feat = {8'h0, m_cur[0]};
      end
      e.drv  = m_dev[4];
      e.mode = m_dev[6];
      q.push_back(e);
      wr(3'd7, opc);
   endtask

   // scoreboard monitor
   always @(negedge clk) begin
      if (rst_n && !done && (cmd_valid || cmd_error)) begin
         checks++;
         if (q.size() == 0) begin
            fail_line("R9", "unexpected pulse", {62'h0, cmd_valid, cmd_error}, 64'h0);
         end else begin
            exp_t e;
            e = q.pop_front();
            if (e.err) begin
               if (!(cmd_error && !cmd_valid))
                  fail_line("R10", {e.tag, " error pulse"}, {62'h0, cmd_valid, cmd_error}, 64'h1);
            end else if (!(cmd_valid && !cmd_error)) begin
               fail_line("R9", {e.tag, " valid pulse"}, {62'h0, cmd_valid, cmd_error}, 64'h2);
            end else if (cmd_op != e.op || cmd_ext != e.ext) begin
               fail_line("R6", {e.tag, " op/ext"}, {61'h0, cmd_op, cmd_ext}, {61'h0, e.op, e.ext});
            end else if (cmd_lba != e.lba) begin
               fail_line(e.ext ? "R3" : "R4", {e.tag, " lba"}, {16'h0, cmd_lba}, {16'h0, e.lba});
            end else if (cmd_count != e.cnt) begin
               fail_line("R7", {e.tag, " count"}, {48'h0, cmd_count}, {48'h0, e.cnt});
            end else if (cmd_feature != e.feat) begin
               fail_line("R8", {e.tag, " feature"}, {48'h0, cmd_feature}, {48'h0, e.feat});
            end else if (cmd_drive1 != e.drv || cmd_lba_mode != e.mode) begin
               fail_line("R5", {e.tag, " device bits"}, {62'h0, cmd_drive1, cmd_lba_mode},
                         {62'h0, e.drv, e.mode});
            end
         end
      end
   end

   initial begin
      model_clear();
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state at the ports
      checks++;
      if (cmd_valid || cmd_error)
         fail_line("R1", "pulses after reset", {62'h0, cmd_valid, cmd_error}, 64'h0);
      issue(8'h20, "R1 read after reset");
      @(negedge clk);

      // R2 R3 R7 R8: 48-bit example
      wr(3'd5, 8'he0);
      wr(3'd2, 8'h56); wr(3'd2, 8'hef);
      wr(3'd3, 8'h34); wr(3'd3, 8'hcd);
      wr(3'd4, 8'h12); wr(3'd4, 8'hab);
      wr(3'd1, 8'h00); wr(3'd1, 8'h08);
      wr(3'd0, 8'h01); wr(3'd0, 8'h02);
      issue(8'h24, "R2 R3 extended read");
      @(negedge clk);

      // R4 R5: 28-bit write with drive 1 and nibble 5
      wr(3'd5, 8'hf5);
      issue(8'h30, "R4 R5 short write");
      @(negedge clk);

      // R6: identify and extended write
      issue(8'hec, "R6 identify");
      issue(8'h34, "R6 extended write");
      @(negedge clk);

      // R10: unknown opcode
      issue(8'h99, "R10 bad opcode");
      @(negedge clk);

      // R11: index 6 changes nothing
      wr(3'd6, 8'h77);
      wr(3'd6, 8'h3c);
      issue(8'h20, "R11 after ignored index");
      @(negedge clk);

      // R9: register write during the pulse, then back-to-back commands
      issue(8'h24, "R9 pulse before overlap");
      wr(3'd2, 8'h99);
      issue(8'h24, "R9 after overlapping write");
      issue(8'h20, "R9 back-to-back");
      @(negedge clk);

      // R7: extended zero count stays zero, short zero gives 256
      wr(3'd1, 8'h00); wr(3'd1, 8'h00);
      issue(8'h34, "R7 extended zero count");
      issue(8'h30, "R7 short zero count");
      repeat (3) @(negedge clk);

      checks++;
      if (q.size() != 0) fail_line("R9", "missing pulses", q.size(), 64'h0);

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         checks++;
         errors++;
         $display("FAIL R9 watchdog: actual=hung expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule